// File: doc/BRIEF.md
# Carrier-Gap Block Programmer for Low-Frequency Tags

This block programs one 32-bit block of a rewritable low-frequency tag. It does this by keying the reader carrier on and off. A write begins when `start` is pulsed while the block is idle. The carrier is then switched on long enough for the antenna to settle and for the tag to power up. Next the carrier is dropped for a start gap. After that a frame of 38 symbols is sent. Each symbol is a stretch of carrier whose length carries the bit value, followed by a fixed-length carrier-off gap. When the last symbol has been sent, the carrier is held on for the programming time and then released.

The frame is a fixed two-bit opcode, a lock bit, the data word and the block address. All durations are counted in pulses of an external microsecond tick. The two long waits are counted in milliseconds, using a prescaler that restarts at the beginning of each phase. The `field_on` output tells the carrier generator when to drive the antenna; the carrier itself is produced outside this block.

Top module: `lfw_gap_writer`

## Requirements
- R1: After reset, and on the cycle after any reset, `field_on`, `busy` and `done` are all 0.
- R2: When `start` is sampled high while the block is idle, `busy` and `field_on` go to 1 on that same clock edge. The carrier then stays on for POWERUP_MS × US_PER_MS `us_tick` pulses.
- R3: After the power-up phase the carrier is off for START_GAP_US tick pulses.
- R4: Each symbol is carrier on for ZERO_US ticks when the bit is 0, or ONE_US ticks when the bit is 1, followed by carrier off for GAP_US ticks.
- R5: Exactly 38 symbols are sent, in this order: 1, 0, a lock bit of 0, then `wr_data` from bit 31 down to bit 0, then `wr_addr` from bit 2 down to bit 0.
- R6: After the gap of the last symbol, the carrier is on for PROG_MS × US_PER_MS ticks and is then switched off.
- R7: `done` is high for exactly one cycle, on the edge where the final carrier-on phase ends. `busy` and `field_on` fall on that same edge.
- R8: A `start` pulse while `busy` is high is ignored: the running frame is unchanged and no second write follows. `wr_data` and `wr_addr` are captured only when a write is accepted.
- R9: Durations advance only on `us_tick` pulses. With one tick every N cycles, every phase after the first lasts N times its tick count in cycles.
- R10: `field_on` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a write |
| wr_data | input | 32 | Data word to be programmed |
| wr_addr | input | 3 | Target block address |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| field_on | output | 1 | High while the carrier should be driven |
| busy | output | 1 | High from an accepted start until the write ends |
| done | output | 1 | One-cycle pulse when the write ends |

## Verification
A wrong phase, a wrong timer count or a wrong shift index shows up at the ports as a `field_on` high or low run of the wrong length. For a bit error, this appears within one symbol of the fault. The bench therefore rebuilds the whole on/off run-length sequence of each write and compares it with the lengths expected from the captured data and address. A miscount in the millisecond prescaler stretches the power-up run, which is the first run of the write, and the programming run, which is the last. A start that was wrongly accepted during a write would appear either as a changed run sequence or as a carrier restart after `done`; the bench watches for both.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_POWER,
    PH_SGAP,
    PH_BIT_ON,
    PH_BIT_GAP,
    PH_PROG
  } phase_e;

  function automatic logic carrier_of(phase_e p);
    return (p == PH_POWER) || (p == PH_BIT_ON) || (p == PH_PROG);
  endfunction
endpackage

// File: rtl/lfw_ms_prescale.sv
module lfw_ms_prescale #(
  parameter int US_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic us_tick,
  output logic ms_tick
);
  localparam int PRE_W = $clog2(US_PER_MS + 1);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(US_PER_MS - 1);

  logic [PRE_W-1:0] pre;

  assign ms_tick = us_tick && (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) pre <= '0;
    else if (us_tick) pre <= (pre == LAST) ? '0 : pre + 1'b1;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
    pre <= LAST); // R9
endmodule

// File: rtl/lfw_phase_timer.sv
module lfw_phase_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = tick && (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    (len != '0) |-> (cnt < len)); // R4
endmodule

// File: rtl/lfw_frame_shift.sv
module lfw_frame_shift #(
  parameter int FRAME_W = 38
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               cur_bit,
  output logic               last
);
  localparam int IDX_W = $clog2(FRAME_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr;
  logic [IDX_W-1:0]   idx;

  assign cur_bit = sr[FRAME_W-1];
  assign last    = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= frame_in;
      idx <= '0;
    end else if (shift) begin
      sr  <= {sr[FRAME_W-2:0], 1'b0};
      idx <= idx + 1'b1;
    end
  end

  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_IDX); // R5
endmodule

// File: rtl/lfw_gap_writer.sv
module lfw_gap_writer #(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 3,
  parameter int US_PER_MS    = 1000,
  parameter int POWERUP_MS   = 150,
  parameter int PROG_MS      = 20,
  parameter int START_GAP_US = 250,
  parameter int GAP_US       = 160,
  parameter int ZERO_US      = 144,
  parameter int ONE_US       = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              us_tick,
  output logic              field_on,
  output logic              busy,
  output logic              done
);
  import lfw_pkg::*;

  localparam int FRAME_W = 3 + DATA_W + ADDR_W;
  localparam int MAX_A   = (POWERUP_MS > PROG_MS) ? POWERUP_MS : PROG_MS;
  localparam int MAX_B   = (START_GAP_US > GAP_US) ? START_GAP_US : GAP_US;
  localparam int MAX_C   = (ONE_US > ZERO_US) ? ONE_US : ZERO_US;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  phase_e           phase, nxt;
  logic             adv, load, shift, fin;
  logic             ms_tick, tsel, expire, cur_bit, last;
  logic [CNT_W-1:0] len;

  lfw_ms_prescale #(.US_PER_MS(US_PER_MS)) u_pre (
    .clk(clk), .rst(rst), .clear(adv || (phase == PH_IDLE)),
    .us_tick(us_tick), .ms_tick(ms_tick)
  );

  lfw_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clear(adv || (phase == PH_IDLE)),
    .tick(tsel), .len(len), .expire(expire)
  );

  lfw_frame_shift #(.FRAME_W(FRAME_W)) u_frm (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .frame_in({3'b100, wr_data, wr_addr}),
    .cur_bit(cur_bit), .last(last)
  );

  always_comb begin
    tsel = ((phase == PH_POWER) || (phase == PH_PROG)) ? ms_tick : us_tick;
    case (phase)
      PH_POWER:   len = CNT_W'(POWERUP_MS);
      PH_SGAP:    len = CNT_W'(START_GAP_US);
      PH_BIT_ON:  len = cur_bit ? CNT_W'(ONE_US) : CNT_W'(ZERO_US);
      PH_BIT_GAP: len = CNT_W'(GAP_US);
      PH_PROG:    len = CNT_W'(PROG_MS);
      default:    len = CNT_W'(1);
    endcase
  end

  always_comb begin
    nxt   = phase;
    adv   = 1'b0;
    load  = 1'b0;
    shift = 1'b0;
    fin   = 1'b0;
    case (phase)
      PH_IDLE: if (start) begin
        nxt = PH_POWER; adv = 1'b1; load = 1'b1;
      end
      PH_POWER: if (expire) begin
        nxt = PH_SGAP; adv = 1'b1;
      end
      PH_SGAP: if (expire) begin
        nxt = PH_BIT_ON; adv = 1'b1;
      end
      PH_BIT_ON: if (expire) begin
        nxt = PH_BIT_GAP; adv = 1'b1;
      end
      PH_BIT_GAP: if (expire) begin
        adv = 1'b1;
        if (last) nxt = PH_PROG;
        else begin
          nxt = PH_BIT_ON; shift = 1'b1;
        end
      end
      PH_PROG: if (expire) begin
        nxt = PH_IDLE; adv = 1'b1; fin = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      field_on <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      phase    <= nxt;
      field_on <= carrier_of(nxt);
      busy     <= (nxt != PH_IDLE);
      done     <= fin;
    end
  end

  AST_FIELD_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    field_on |-> busy); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !field_on && $past(busy))); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !$rose(phase == PH_POWER)); // R8
endmodule

// File: tb/sim_lfw_gap_writer.sv
module sim_lfw_gap_writer;
  localparam int CLK_PERIOD = 10;
  localparam int U = 4, P = 3, PR = 2, SG = 5, GP = 3, ZR = 2, ON = 6;
  localparam int NVEC = 5;
  localparam int NSEG = 79;
  // {poke, div[1:0], addr[2:0], data[31:0]}
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b0, 2'd1, 3'd0, 32'h0000_0000},
    {1'b0, 2'd1, 3'd7, 32'hFFFF_FFFF},
    {1'b1, 2'd1, 3'd5, 32'h8000_0001},
    {1'b0, 2'd2, 3'd2, 32'h1234_5678},
    {1'b1, 2'd1, 3'd3, 32'hDEAD_BEEF}
  };

  logic clk = 0, rst = 1, start = 0, us_tick = 0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wr_addr = '0;
  logic field_on, busy, done;
  int div = 1, nchk = 0, nerr = 0, tcnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfw_gap_writer #(.US_PER_MS(U), .POWERUP_MS(P), .PROG_MS(PR),
    .START_GAP_US(SG), .GAP_US(GP), .ZERO_US(ZR), .ONE_US(ON)) u0 (
    .clk(clk), .rst(rst), .start(start), .wr_data(wr_data), .wr_addr(wr_addr),
    .us_tick(us_tick), .field_on(field_on), .busy(busy), .done(done));

  initial forever begin
    @(negedge clk);
    us_tick = (tcnt == 0);
    tcnt = (tcnt + 1) % div;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input logic [2:0] a,
                          input bit poke);
    int lens[100];
    int exp_len[NSEG];
    int seg = 0, run = 1, cyc = 0, bad = -1;
    logic lvl = 1;
    bit done_seen = 0;
    logic [37:0] f = {3'b100, d, a};
    exp_len[0] = P * U * div;
    exp_len[1] = SG * div;
    for (int i = 0; i < 38; i++) begin
      exp_len[2 + 2*i] = (f[37-i] ? ON : ZR) * div;
      exp_len[3 + 2*i] = GP * div;
    end
    exp_len[78] = PR * U * div;
    wr_data = d; wr_addr = a; start = 1;
    @(negedge clk);
    start = 0; wr_data = ~d; wr_addr = ~a;
    chk(busy && field_on, "R2", "busy/field after start", {busy, field_on}, 3);
    while (cyc < 5000) begin
      start = (poke && seg == 3 && run == 1);
      @(negedge clk);
      cyc++;
      if (!busy) begin
        if (seg < 100) lens[seg] = run;
        seg++;
        done_seen = done;
        break;
      end
      if (field_on == lvl) run++;
      else begin
        if (seg < 100) lens[seg] = run;
        seg++; lvl = field_on; run = 1;
      end
    end
    start = 0;
    chk(seg == NSEG, "R5", "segment count", seg, NSEG);
    if (seg == NSEG) begin
      if (div == 1)
        chk(lens[0] == exp_len[0], "R2", "power-up run", lens[0], exp_len[0]);
      else
        chk(lens[0] <= exp_len[0] && lens[0] > exp_len[0] - div, "R9",
            "power-up run scaled", lens[0], exp_len[0]);
      chk(lens[1] == exp_len[1], "R3", "start gap run", lens[1], exp_len[1]);
      for (int i = 2; i < 78; i++)
        if (bad < 0 && lens[i] != exp_len[i]) bad = i;
      chk(bad < 0, "R4 R5", "symbol runs first mismatch segment",
          bad, -1);
      if (bad >= 0)
        chk(0, "R4", "symbol run length", lens[bad], exp_len[bad]);
      chk(lens[78] == exp_len[78], "R6", "program run", lens[78], exp_len[78]);
    end
    chk(done_seen && !field_on, "R7", "done with field off",
        {done_seen, field_on}, 2);
    @(negedge clk);
    chk(!done, "R7", "done single cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(!busy && !field_on, "R10", "idle after write", {busy, field_on}, 0);
    if (poke)
      chk(!busy, "R8", "start during write not queued", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!field_on && !busy && !done, "R1", "reset outputs",
        {field_on, busy, done}, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NVEC; v++) begin
      div = int'(VEC[v][36:35]);
      tcnt = 0;
      repeat (3) @(negedge clk);
      do_write(VEC[v][31:0], VEC[v][34:32], VEC[v][37]);
    end
    div = 1;
    // reset in the middle of a write
    wr_data = 32'h5555_AAAA; wr_addr = 3'd1; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(!field_on && !busy && !done, "R1", "outputs after mid-write reset",
        {field_on, busy, done}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    do_write(32'h0F0F_00FF, 3'd6, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule